// File: doc/BRIEF.md
# Register-Mapped 24-Pin GPIO Expander Core

This block is the register bank and pad control of a 24-pin general-purpose I/O expander. A host reaches it through a simple byte-wide register port: an 8-bit address, 8-bit write data, a write strobe, a read strobe and registered 8-bit read data. A serial front end outside this block turns bus transactions into these strobes.

The pins form a main group (pins 0 to 15) and an alternate group (pins 16 to 23). Each group has its own enable bit. Every configuration function spreads its 24 bits over three consecutive byte registers. Pin n sits in register base + n/8 at bit n%8.

The output latch cannot be written directly. It changes only through write-one-to-set and write-one-to-clear registers, so software never has to read, modify and write it back. One type bit per pin selects the drive style for outputs or enables a pull for inputs. A second bit then picks the pull direction. Pin levels pass through a two-stage synchronizer before they are reported. A soft reset clears the whole configuration and opens a boot window. During that window the core reports busy and ignores writes.

Top module: `gpio_exp_core`

## Requirements
- R1: While reset is low and right after it, every configuration register is 0, all pads have output enable and pull enable low, and read data is 0x00. `busy` is high for exactly BOOT_CYCLES clock cycles after reset is released.
- R2: Register 0x00 returns the identifier. The identifier is the bitwise complement of the 8-bit bus address byte, {BUS_ADDR_BASE | addr_strap, 1'b0}. With the default base 0x42, strap 0 reads 0x7B and strap 1 reads 0x79.
- R3: Register 0x01 returns FW_MAJOR and register 0x02 returns FW_MINOR. Any address that is not mapped reads 0x00.
- R4: Direction (0x60-0x62), type (0x64-0x66) and pull select (0x68-0x6A) hold the byte written and read it back. Pin n lives at base + n/8, bit n%8.
- R5: Writing to the set registers (0x6C-0x6E) sets the latch bit for every 1 in the byte. Writing to the clear registers (0x70-0x72) clears the latch bit for every 1. Zero bits leave the latch unchanged. Reading either register bank returns the latch.
- R6: For an enabled output pin (direction 1) with type 1 (push-pull), output enable is 1 and the pad value follows the latch.
- R7: For an enabled output pin with type 0 (open-drain), the pad value is 0 and output enable is the inverse of the latch. The pad never drives a 1 without its enable.
- R8: For an enabled input pin (direction 0), output enable is 0. Pull enable equals the type bit. Pull-up (pull select 1) or pull-down (pull select 0) applies only while pull enable is 1.
- R9: System control at 0x40 has bit 0 enabling pins 0-15 and bit 3 enabling pins 16-23. The register reads back those two bits. The pins of a disabled group have output enable, pad value and pulls at 0, and their status bits read 0.
- R10: Status registers 0x10-0x12 report pin levels through a two-flop synchronizer. A read strobe sampled at the first or second clock edge after an input change returns the old level. A read strobe sampled at the third edge returns the new level.
- R11: Writing 1 to bit 7 of 0x40 resets every configuration register to 0 and holds `busy` high for BOOT_CYCLES cycles. Writes accepted while `busy` is high have no effect. Reads still work during that time.
- R12: `reg_rdata` updates on the clock edge that samples `reg_rd` high and keeps its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Address strap, forms bit 0 of the 7-bit bus address |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Read data, registered |
| busy | output | 1 | High during the boot window after a reset |
| pin_in | input | 24 | Asynchronous pad input levels |
| pad_out | output | 24 | Pad output value |
| pad_oe | output | 24 | Pad output enable |
| pad_pull_en | output | 24 | Pad pull resistor enable |
| pad_pull_up | output | 24 | Pull direction, 1 for up, 0 for down |

## Verification
The bench builds the core with BOOT_CYCLES set to 16 instead of the multi-hundred-thousand default. This makes the boot window short enough that its exact length can be counted after both hardware reset and soft reset. It also lets the bench try writes inside that window. The firmware bytes are left at their defaults. The address strap is driven to both values, so both identifier encodings are reached.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;

    localparam int BANKS     = 3;
    localparam int BANK_W    = 8;
    localparam int NUM_PINS  = BANKS * BANK_W;
    localparam int MAIN_PINS = 16;
    localparam int ALT_PINS  = NUM_PINS - MAIN_PINS;

    localparam logic [7:0] A_ID      = 8'h00;
    localparam logic [7:0] A_FW_MAJ  = 8'h01;
    localparam logic [7:0] A_FW_MIN  = 8'h02;
    localparam logic [7:0] A_STATUS  = 8'h10;
    localparam logic [7:0] A_SYSCTRL = 8'h40;
    localparam logic [7:0] A_DIR     = 8'h60;
    localparam logic [7:0] A_TYPE    = 8'h64;
    localparam logic [7:0] A_PULL    = 8'h68;
    localparam logic [7:0] A_SET     = 8'h6C;
    localparam logic [7:0] A_CLR     = 8'h70;

    localparam int SC_MAIN = 0;
    localparam int SC_ALT  = 3;
    localparam int SC_RST  = 7;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] drv;
        logic [NUM_PINS-1:0] pull;
        logic [NUM_PINS-1:0] latch;
        logic                en_main;
        logic                en_alt;
    } cfg_t;

    typedef struct packed {
        cfg_t       cfg;
        logic [7:0] rdata;
    } regs_t;

endpackage

// File: rtl/gpio_exp_sync.sv
module gpio_exp_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_exp_boot.sv
module gpio_exp_boot #(
    parameter int BOOT_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = (BOOT_CYCLES < 1) ? 1 : $clog2(BOOT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BOOT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/gpio_exp_pad.sv
module gpio_exp_pad #(
    parameter int N = 24
) (
    input  logic [N-1:0] dir,
    input  logic [N-1:0] drv,
    input  logic [N-1:0] pull,
    input  logic [N-1:0] latch,
    input  logic [N-1:0] en,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_pull_en,
    output logic [N-1:0] pad_pull_up
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        always_comb begin
            pad_out[p]     = 1'b0;
            pad_oe[p]      = 1'b0;
            pad_pull_en[p] = 1'b0;
            pad_pull_up[p] = 1'b0;
            if (en[p]) begin
                if (dir[p]) begin
                    if (drv[p]) begin
                        pad_oe[p]  = 1'b1;
                        pad_out[p] = latch[p];
                    end else begin
                        pad_oe[p]  = ~latch[p];
                    end
                end else begin
                    pad_pull_en[p] = drv[p];
                    pad_pull_up[p] = drv[p] & pull[p];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_exp_core.sv
module gpio_exp_core
    import gpio_exp_pkg::*;
#(
    parameter int         BOOT_CYCLES   = 500000,
    parameter logic [6:0] BUS_ADDR_BASE = 7'h42,
    parameter logic [7:0] FW_MAJOR      = 8'h02,
    parameter logic [7:0] FW_MINOR      = 8'h01,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_strap,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_wr,
    input  logic                reg_rd,
    output logic [7:0]          reg_rdata,
    output logic                busy,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pull_en,
    output logic [NUM_PINS-1:0] pad_pull_up
);

    regs_t               r_d, r_q;
    logic                wr_ok;
    logic                soft_rst;
    logic [6:0]          bus_addr;
    logic [7:0]          rd_val;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] grp_en;
    logic [NUM_PINS-1:0] status;

    assign bus_addr = BUS_ADDR_BASE | {6'b0, addr_strap};
    assign grp_en   = {{ALT_PINS{r_q.cfg.en_alt}}, {MAIN_PINS{r_q.cfg.en_main}}};
    assign status   = pin_sync & grp_en;
    assign wr_ok    = reg_wr & ~busy;
    assign soft_rst = wr_ok && (reg_addr == A_SYSCTRL) && reg_wdata[SC_RST];

    gpio_exp_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_exp_boot #(
        .BOOT_CYCLES (BOOT_CYCLES)
    ) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .start (soft_rst),
        .busy  (busy)
    );

    gpio_exp_pad #(
        .N (NUM_PINS)
    ) u_pad (
        .dir         (r_q.cfg.dir),
        .drv         (r_q.cfg.drv),
        .pull        (r_q.cfg.pull),
        .latch       (r_q.cfg.latch),
        .en          (grp_en),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

    // Read mux
    always_comb begin
        rd_val = 8'h00;
        if (reg_addr == A_ID) begin
            rd_val = ~{bus_addr, 1'b0};
        end else if (reg_addr == A_FW_MAJ) begin
            rd_val = FW_MAJOR;
        end else if (reg_addr == A_FW_MIN) begin
            rd_val = FW_MINOR;
        end else if (reg_addr == A_SYSCTRL) begin
            rd_val[SC_MAIN] = r_q.cfg.en_main;
            rd_val[SC_ALT]  = r_q.cfg.en_alt;
        end
        for (int b = 0; b < BANKS; b++) begin
            if (reg_addr == A_STATUS + 8'(b)) rd_val = status[b*BANK_W +: BANK_W];
            if (reg_addr == A_DIR + 8'(b))    rd_val = r_q.cfg.dir[b*BANK_W +: BANK_W];
            if (reg_addr == A_TYPE + 8'(b))   rd_val = r_q.cfg.drv[b*BANK_W +: BANK_W];
            if (reg_addr == A_PULL + 8'(b))   rd_val = r_q.cfg.pull[b*BANK_W +: BANK_W];
            if (reg_addr == A_SET + 8'(b))    rd_val = r_q.cfg.latch[b*BANK_W +: BANK_W];
            if (reg_addr == A_CLR + 8'(b))    rd_val = r_q.cfg.latch[b*BANK_W +: BANK_W];
        end
    end

    // Next-state
    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            if (reg_addr == A_SYSCTRL) begin
                if (reg_wdata[SC_RST]) begin
                    r_d.cfg = '0;
                end else begin
                    r_d.cfg.en_main = reg_wdata[SC_MAIN];
                    r_d.cfg.en_alt  = reg_wdata[SC_ALT];
                end
            end
            for (int b = 0; b < BANKS; b++) begin
                if (reg_addr == A_DIR + 8'(b))
                    r_d.cfg.dir[b*BANK_W +: BANK_W] = reg_wdata;
                if (reg_addr == A_TYPE + 8'(b))
                    r_d.cfg.drv[b*BANK_W +: BANK_W] = reg_wdata;
                if (reg_addr == A_PULL + 8'(b))
                    r_d.cfg.pull[b*BANK_W +: BANK_W] = reg_wdata;
                if (reg_addr == A_SET + 8'(b))
                    r_d.cfg.latch[b*BANK_W +: BANK_W] =
                        r_q.cfg.latch[b*BANK_W +: BANK_W] | reg_wdata;
                if (reg_addr == A_CLR + 8'(b))
                    r_d.cfg.latch[b*BANK_W +: BANK_W] =
                        r_q.cfg.latch[b*BANK_W +: BANK_W] & ~reg_wdata;
            end
        end
        if (reg_rd) begin
            r_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;

endmodule

// File: rtl/gpio_exp_chk.sv
module gpio_exp_chk #(
    parameter int BOOT_CYCLES = 500000,
    parameter int N           = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         reg_rd,
    input logic [7:0]   reg_rdata,
    input logic [N-1:0] pad_out,
    input logic [N-1:0] pad_oe,
    input logic [N-1:0] pad_pull_en,
    input logic [N-1:0] pad_pull_up
);

    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
        end
    end

    // R1
    boot_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == BOOT_CYCLES));

    // R7
    no_undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    // R8
    pull_dir_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pull_up & ~pad_pull_en) == '0));

    // R8
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_pull_en) == '0));

    // R11
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pad_oe) && $stable(pad_out) &&
                  $stable(pad_pull_en) && $stable(pad_pull_up)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind gpio_exp_core gpio_exp_chk #(
    .BOOT_CYCLES (BOOT_CYCLES),
    .N           (gpio_exp_pkg::NUM_PINS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up)
);

// File: tb/sim_gpio_exp_core.sv
`timescale 1ns/1ps
module sim_gpio_exp_core;

    localparam int  BOOT = 16;
    localparam real HALF = 10.0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        addr_strap = 0;
    logic [7:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic        reg_wr = 0;
    logic        reg_rd = 0;
    logic [7:0]  reg_rdata;
    logic        busy;
    logic [23:0] pin_in = 0;
    logic [23:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    logic  rd_seen = 0;

    always #(HALF) clk = ~clk;

    gpio_exp_core #(.BOOT_CYCLES(BOOT)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .busy(busy),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data one edge after the strobe
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, {24'h0, reg_rdata}, {24'h0, it.exp});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", busy, 1);
        chk("R1 rdata in reset", reg_rdata, 0);
        chk("R1 oe in reset", pad_oe, 0);
        chk("R1 pull in reset", pad_pull_en, 0);
        rst_n = 1;
        count_busy(n);
        chk("R1 boot window length", n, BOOT);
        rd(8'h60, 8'h00, "R1 dir after reset");
        rd(8'h6C, 8'h00, "R1 latch after reset");

        // R2 identifier
        rd(8'h00, 8'h7B, "R2 id strap0");
        addr_strap = 1;
        rd(8'h00, 8'h79, "R2 id strap1");
        addr_strap = 0;

        // R3 version and unmapped
        rd(8'h01, 8'h02, "R3 fw major");
        rd(8'h02, 8'h01, "R3 fw minor");
        rd(8'h33, 8'h00, "R3 unmapped 0x33");
        rd(8'h63, 8'h00, "R3 unmapped 0x63");

        // R9 enable main only
        wr(8'h40, 8'h01);
        rd(8'h40, 8'h01, "R9 sysctrl readback");

        // R4 config regs
        wr(8'h60, 8'h30); wr(8'h64, 8'h13); wr(8'h68, 8'h01);
        wr(8'h61, 8'hC3); wr(8'h65, 8'h5A); wr(8'h69, 8'h99);
        wr(8'h62, 8'h02); wr(8'h66, 8'h02); wr(8'h6A, 8'h80);
        rd(8'h60, 8'h30, "R4 dir0");
        rd(8'h61, 8'hC3, "R4 dir1");
        rd(8'h62, 8'h02, "R4 dir2");
        rd(8'h65, 8'h5A, "R4 type1");
        rd(8'h6A, 8'h80, "R4 pull2");

        // R6 push-pull pin 4
        chk("R6 pin4 oe", pad_oe[4], 1);
        chk("R6 pin4 out low", pad_out[4], 0);
        wr(8'h6C, 8'h10);
        chk("R6 pin4 out high", pad_out[4], 1);
        // R7 open-drain pin 5 with latch 0 drives low
        chk("R7 pin5 oe latch0", pad_oe[5], 1);
        chk("R7 pin5 out", pad_out[5], 0);
        wr(8'h6C, 8'h20);
        chk("R7 pin5 released", pad_oe[5], 0);
        chk("R7 pin5 out stays 0", pad_out[5], 0);

        // R5 set/clear semantics
        rd(8'h6C, 8'h30, "R5 latch after sets");
        wr(8'h6C, 8'h00);
        rd(8'h70, 8'h30, "R5 zero set no change");
        wr(8'h70, 8'h10);
        rd(8'h6C, 8'h20, "R5 clear bit4");
        chk("R6 pin4 out after clear", pad_out[4], 0);
        wr(8'h70, 8'h00);
        rd(8'h6C, 8'h20, "R5 zero clear no change");

        // R8 input pulls
        chk("R8 pin0 pull en", pad_pull_en[0], 1);
        chk("R8 pin0 pull up", pad_pull_up[0], 1);
        chk("R8 pin1 pull en", pad_pull_en[1], 1);
        chk("R8 pin1 pull down", pad_pull_up[1], 0);
        chk("R8 pin2 no bias", pad_pull_en[2], 0);
        chk("R8 pin0 oe", pad_oe[0], 0);

        // R9 alternate group gated
        wr(8'h6E, 8'h02);
        chk("R9 pin17 alt off", pad_oe[17], 0);
        wr(8'h40, 8'h09);
        chk("R9 pin17 alt on oe", pad_oe[17], 1);
        chk("R9 pin17 alt on out", pad_out[17], 1);

        // R10 status and sync latency
        pin_in = 24'hA5_3C_81;
        repeat (3) @(negedge clk);
        rd(8'h10, 8'h81, "R10 status0");
        rd(8'h11, 8'h3C, "R10 status1");
        rd(8'h12, 8'hA5, "R10 status2");
        pin_in[8] = 1'b1;
        rd(8'h11, 8'h3C, "R10 first edge old");
        rd(8'h11, 8'h3C, "R10 second edge old");
        rd(8'h11, 8'h3D, "R10 third edge new");

        // R9 main disabled
        wr(8'h40, 8'h08);
        chk("R9 pin4 main off oe", pad_oe[4], 0);
        chk("R9 pin0 main off pull", pad_pull_en[0], 0);
        chk("R9 pin17 still on", pad_oe[17], 1);
        rd(8'h10, 8'h00, "R9 status masked");
        rd(8'h12, 8'hA5, "R9 alt status live");
        wr(8'h40, 8'h01);
        rd(8'h12, 8'h00, "R9 alt status masked");

        // R12 hold
        held = 8'h00;
        repeat (3) @(negedge clk);
        chk("R12 rdata held", reg_rdata, held);

        // R11 soft reset
        wr(8'h40, 8'h80);
        chk("R11 busy after soft reset", busy, 1);
        chk("R11 oe cleared", pad_oe, 0);
        wr(8'h60, 8'hFF);
        rd(8'h60, 8'h00, "R11 read during busy");
        count_busy(n);
        chk("R11 soft boot window", n + 2, BOOT);
        rd(8'h60, 8'h00, "R11 write in busy ignored");
        rd(8'h40, 8'h00, "R11 sysctrl cleared");
        rd(8'h6E, 8'h00, "R11 latch cleared");
        wr(8'h60, 8'h0F);
        rd(8'h60, 8'h0F, "R11 writes accepted after");

        repeat (2) @(negedge clk);
        chk("scoreboard drained", sb.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule